// File: doc/BRIEF.md
# Time-Skewed Sliced ALU

This block is a 32-bit arithmetic and logic unit built as eight identical 4-bit pipelined slices. The operand bits are not all presented in the same cycle. The lowest nibble enters first, and each higher nibble enters one clock later than the nibble below it. The result leaves in the same staggered order. Each slice resolves its internal carry-lookahead while it waits for the carry from the slice below. That carry is produced one cycle after the lower slice consumes its own carry-in, which is the cycle in which the upper slice needs it.

Each slice can take operand A from its own latest result instead of from the input pins. A dependent operation therefore starts in each slice as soon as that slice has finished the previous operation. It does not wait for the whole word. Independent operations can be issued every cycle. A chain of dependent operations can be issued every eight cycles, which is the depth of one slice. The full word takes fifteen cycles, from the first nibble entering to the last nibble leaving. The operation code and the forward-select bit are given together with the lowest nibble, and the block delays them internally for each higher slice.

Top module: `blkskew_alu`

## Requirements
- R1: Nibble k (bits 4k+3..4k) of `a_i`/`b_i` for an operation is driven k cycles after that operation's nibble 0. Nibble k of its result appears on `res_o` exactly 8 cycles after that nibble's operands were driven, so the last nibble appears 15 cycles after nibble 0 went in.
- R2: `op_i` encoding: 0 ADD (a+b), 1 SUB (a-b), 2 AND, 3 OR, 4 XOR, 5 NOR (~(a|b)), 6 EQ (bitwise XNOR, so all ones exactly when a equals b), 7 SLT (produces the same difference as SUB).
- R3: Carries ripple correctly through all eight slices, so ADD, SUB and SLT give the exact 32-bit two's-complement result. This includes a carry crossing every slice boundary.
- R4: `cout_o` is the carry out of bit 31 for ADD, SUB and SLT (for SUB, 1 means no borrow). It is 0 for every logic operation, and it is valid in the same cycle as the top result nibble.
- R5: When `fwd_i` is 1 in an operation's issue cycle, every slice uses its own current `res_o` nibble as operand A, and the `a_i` bits driven for that operation have no effect. Because a slice is 8 deep, this is the result of the operation issued exactly 8 cycles earlier. `b_i` is still taken from the pins.
- R6: A new independent operation can be issued in every cycle, and each one produces its own correct result.
- R7: `op_i` and `fwd_i` are sampled with nibble 0 only. Each slice applies the controls belonging to its own operation, even when the controls change in every cycle.
- R8: A synchronous active-low reset clears the pipeline. After reset, `res_o` and `cout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | 32 | Operand A, nibble k driven k cycles after nibble 0 |
| b_i | input | 32 | Operand B, skewed the same way as A |
| op_i | input | 3 | Operation code, given with nibble 0 |
| fwd_i | input | 1 | 1 selects each slice's own result as operand A |
| res_o | output | 32 | Result, nibble k leaves k cycles after nibble 0 |
| cout_o | output | 1 | Carry out of bit 31, aligned with the top nibble |

## Verification
The bench builds the block with its default shape of eight slices of four bits. That shape gives carry-lookahead trees of two levels and a skew of fifteen cycles. It also lets a carry from a single add ripple through seven slice boundaries, which the cases 0x0FFFFFFF+1 and 0xFFFFFFFF+1 exercise. A long doubling chain, with a result fed back every eight cycles, checks that each slice picks up its own previous nibble at the right cycle, up to overflow. Random streams mix all eight codes with forwarding in every cycle, so controls that are shifted by one slice would corrupt the results.

// File: rtl/bsalu_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the time-skewed sliced ALU.
// Assumes every slice has the same stage plan: carry needed at stage
// CIN_STAGE, result registered at stage RES_STAGE.
package bsalu_pkg;

    localparam int CIN_STAGE = 5;
    localparam int RES_STAGE = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_NOR = 3'd5,
        OP_EQ  = 3'd6,
        OP_SLT = 3'd7
    } alu_op_e;

    // Per-slice control word derived from the operation code
    typedef struct packed {
        logic arith;    // result taken from the adder
        logic use_and;  // logic term includes a&b
        logic use_xor;  // logic term includes a^b
        logic inv_a;    // complement A before use
        logic inv_b;    // complement B before use
        logic carry0;   // carry into the lowest slice
    } alu_ctrl_t;

    localparam int CTRL_W = $bits(alu_ctrl_t);

    // Map an operation code onto the control word
    function automatic alu_ctrl_t decode_op(input logic [2:0] code);
        alu_ctrl_t c;
        c = '0;
        case (code)
            OP_ADD: begin c.arith = 1'b1; c.use_xor = 1'b1; end
            OP_SUB, OP_SLT: begin
                c.arith = 1'b1; c.use_xor = 1'b1;
                c.inv_b = 1'b1; c.carry0 = 1'b1;
            end
            OP_AND: c.use_and = 1'b1;
            OP_OR:  begin c.use_and = 1'b1; c.use_xor = 1'b1; end
            OP_XOR: c.use_xor = 1'b1;
            OP_NOR: begin
                c.use_and = 1'b1; c.inv_a = 1'b1; c.inv_b = 1'b1;
            end
            default: begin c.use_xor = 1'b1; c.inv_b = 1'b1; end // OP_EQ
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsalu_delay.sv
`timescale 1ns/1ps
// Fixed-length register delay line.
// Assumes DEPTH >= 1; every stage clears on synchronous reset.
module bsalu_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [DEPTH];

    // Shift the word one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[DEPTH-1];

endmodule

// File: rtl/bsalu_slice.sv
`timescale 1ns/1ps
// One W-bit ALU slice, RES_STAGE cycles deep.
// Stage 1 registers the operands, with operand A muxed against the
// slice's own result. Stage 2 forms generate/propagate and the logic
// term. A parallel-prefix tree follows, one register per level, padded
// up to CIN_STAGE. The carry-in is consumed there, so it must arrive
// CIN_STAGE cycles after the operands. The lowest slice (FIRST) makes
// its own carry by delaying the control carry bit.
module bsalu_slice
    import bsalu_pkg::*;
#(
    parameter int W     = 4,
    parameter bit FIRST = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_ctrl_t ctrl_i,
    input  logic      fwd_i,
    input  logic      cin_i,
    output logic      cout_early_o,
    output logic [W-1:0] res_o
);

    localparam int LVLS   = $clog2(W);
    localparam int PAD    = CIN_STAGE - 2 - LVLS;
    localparam int SIDE_W = 2 * W + 1;

    logic [W-1:0] res_q;

    // ---------------- stage 1: operand capture ----------------
    logic [W-1:0] a1, b1;
    alu_ctrl_t    c1;

    // Register operands; A comes from the own result when forwarding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1 <= '0;
            b1 <= '0;
            c1 <= '0;
        end else begin
            a1 <= fwd_i ? res_q : a_i;
            b1 <= b_i;
            c1 <= ctrl_i;
        end
    end

    logic [W-1:0] x1, y1;
    assign x1 = a1 ^ {W{c1.inv_a}};
    assign y1 = b1 ^ {W{c1.inv_b}};

    // ---------------- stage 2 and prefix levels ----------------
    logic [W-1:0] gl [LVLS+1];
    logic [W-1:0] pl [LVLS+1];
    logic [W-1:0] gn [LVLS];
    logic [W-1:0] pn [LVLS];
    logic [W-1:0] lg2;
    logic         ar2;

    // Prefix level l merges each bit with the top of the block below it
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (((i >> l) & 1) == 1) begin : g_merge
                localparam int J = ((i >> l) << l) - 1;
                assign gn[l][i] = gl[l][i] | (pl[l][i] & gl[l][J]);
                assign pn[l][i] = pl[l][i] & pl[l][J];
            end else begin : g_pass
                assign gn[l][i] = gl[l][i];
                assign pn[l][i] = pl[l][i];
            end
        end
    end

    // Register bit terms, then one prefix level per stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l <= LVLS; l++) begin
                gl[l] <= '0;
                pl[l] <= '0;
            end
            lg2 <= '0;
            ar2 <= 1'b0;
        end else begin
            gl[0] <= x1 & y1;
            pl[0] <= x1 ^ y1;
            lg2   <= ({W{c1.use_and}} & (x1 & y1)) ^ ({W{c1.use_xor}} & (x1 ^ y1));
            ar2   <= c1.arith;
            for (int l = 0; l < LVLS; l++) begin
                gl[l+1] <= gn[l];
                pl[l+1] <= pn[l];
            end
        end
    end

    // ---------------- balance to the carry stage ----------------
    logic [W-1:0] g5, p5;
    if (PAD > 0) begin : g_pad
        logic [2*W-1:0] gp_d;
        bsalu_delay #(.WIDTH(2 * W), .DEPTH(PAD)) u_gp_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  ({gl[LVLS], pl[LVLS]}),
            .q_o  (gp_d)
        );
        assign {g5, p5} = gp_d;
    end else begin : g_nopad
        assign g5 = gl[LVLS];
        assign p5 = pl[LVLS];
    end

    logic [SIDE_W-1:0] side5;
    bsalu_delay #(.WIDTH(SIDE_W), .DEPTH(CIN_STAGE - 2)) u_side_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({pl[0], lg2, ar2}),
        .q_o  (side5)
    );

    logic [W-1:0] hs5, lg5;
    logic         ar5;
    assign {hs5, lg5, ar5} = side5;

    logic cin0_d;
    bsalu_delay #(.WIDTH(1), .DEPTH(CIN_STAGE - 1)) u_cin_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (c1.carry0),
        .q_o  (cin0_d)
    );

    // ---------------- stage 5: carry resolution ----------------
    logic         cin5;
    logic [W-1:0] cv5;
    logic         co5;
    assign cin5 = FIRST ? cin0_d : cin_i;

    // Expand group terms with the incoming carry into per-bit carries
    always_comb begin
        cv5[0] = cin5;
        for (int i = 1; i < W; i++) cv5[i] = g5[i-1] | (p5[i-1] & cin5);
    end

    assign co5 = ar5 & (g5[W-1] | (p5[W-1] & cin5));

    // ---------------- stages 6 to 8: sum and output ----------------
    logic [W-1:0] cv6, hs6, lg6, r7;
    logic         ar6, co6;

    // Capture carries and the early carry-out for the next slice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv6 <= '0;
            hs6 <= '0;
            lg6 <= '0;
            ar6 <= 1'b0;
            co6 <= 1'b0;
        end else begin
            cv6 <= cv5;
            hs6 <= hs5;
            lg6 <= lg5;
            ar6 <= ar5;
            co6 <= co5;
        end
    end

    // Form the sum or pass the logic term, then hold it at the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r7    <= '0;
            res_q <= '0;
        end else begin
            r7    <= ar6 ? (hs6 ^ cv6) : lg6;
            res_q <= r7;
        end
    end

    assign cout_early_o = co6;
    assign res_o        = res_q;

endmodule

// File: rtl/blkskew_alu.sv
`timescale 1ns/1ps
// Time-skewed ALU built from NUM_SLICES slices of SLICE_W bits.
// Assumes the caller drives slice k operands k cycles after slice 0
// and gives op_i/fwd_i with slice 0. Controls are delayed k cycles
// per slice. The early carry of slice k-1 reaches slice k in the cycle
// its carry stage needs it.
module blkskew_alu
    import bsalu_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] b_i,
    input  logic [2:0]                    op_i,
    input  logic                          fwd_i,
    output logic [SLICE_W*NUM_SLICES-1:0] res_o,
    output logic                          cout_o
);

    localparam int CF_W = CTRL_W + 1;

    logic [CF_W-1:0]     cf_in;
    logic [NUM_SLICES:0] cy;

    assign cf_in = {decode_op(op_i), fwd_i};
    assign cy[0] = 1'b0;

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        logic [CF_W-1:0] cf_k;
        alu_ctrl_t       ck;

        if (k == 0) begin : g_ctl0
            assign cf_k = cf_in;
        end else begin : g_ctlk
            bsalu_delay #(.WIDTH(CF_W), .DEPTH(k)) u_ctl_dly (
                .clk  (clk),
                .rst_n(rst_n),
                .d_i  (cf_in),
                .q_o  (cf_k)
            );
        end

        assign ck = cf_k[CF_W-1:1];

        bsalu_slice #(.W(SLICE_W), .FIRST(k == 0)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .a_i         (a_i[k*SLICE_W +: SLICE_W]),
            .b_i         (b_i[k*SLICE_W +: SLICE_W]),
            .ctrl_i      (ck),
            .fwd_i       (cf_k[0]),
            .cin_i       (cy[k]),
            .cout_early_o(cy[k+1]),
            .res_o       (res_o[k*SLICE_W +: SLICE_W])
        );
    end

    logic co_d1, co_d2;

    // Align the top early carry with the top result nibble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            co_d1 <= 1'b0;
            co_d2 <= 1'b0;
        end else begin
            co_d1 <= cy[NUM_SLICES];
            co_d2 <= co_d1;
        end
    end

    assign cout_o = co_d2;

endmodule

// File: rtl/blkskew_alu_chk.sv
`timescale 1ns/1ps
// Checker for blkskew_alu. For every slice it keeps its own record of
// the operation and operand nibbles that slice received. It then
// compares the nibble leaving RES_STAGE cycles later. Forwarded
// operands are taken from res_o, as a user sees them.
module blkskew_alu_chk
    import bsalu_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [SLICE_W*NUM_SLICES-1:0] a_i,
    input logic [SLICE_W*NUM_SLICES-1:0] b_i,
    input logic [2:0]                    op_i,
    input logic                          fwd_i,
    input logic [SLICE_W*NUM_SLICES-1:0] res_o,
    input logic                          cout_o
);

    typedef struct packed {
        logic       vld;
        logic [2:0] op;
        logic       fwd;
    } tag_t;

    typedef struct packed {
        logic               vld;
        logic [2:0]         op;
        logic [SLICE_W-1:0] a;
        logic [SLICE_W-1:0] b;
    } rec_t;

    function automatic logic [SLICE_W-1:0] nib_ref(input logic [2:0] op,
                                                   input logic [SLICE_W-1:0] a,
                                                   input logic [SLICE_W-1:0] b);
        case (op)
            3'd0:       return a + b;
            3'd1, 3'd7: return a - b;
            3'd2:       return a & b;
            3'd3:       return a | b;
            3'd4:       return a ^ b;
            3'd5:       return ~(a | b);
            default:    return ~(a ^ b);
        endcase
    endfunction

    function automatic logic is_logic(input logic [2:0] op);
        return (op >= 3'd2) && (op <= 3'd6);
    endfunction

    tag_t tag_now;
    tag_t tag_sh [NUM_SLICES-1];
    assign tag_now = '{vld: 1'b1, op: op_i, fwd: fwd_i};

    // Delay the issued controls once per slice position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_SLICES - 1; j++) tag_sh[j] <= '0;
        end else begin
            tag_sh[0] <= tag_now;
            for (int j = 1; j < NUM_SLICES - 1; j++) tag_sh[j] <= tag_sh[j-1];
        end
    end

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_k
        tag_t               tk;
        logic [SLICE_W-1:0] ak, bk, rk, ek;
        rec_t               pipe [RES_STAGE];
        rec_t               outr;

        if (k == 0) begin : g_t0
            assign tk = tag_now;
        end else begin : g_tk
            assign tk = tag_sh[k-1];
        end

        assign ak   = a_i[k*SLICE_W +: SLICE_W];
        assign bk   = b_i[k*SLICE_W +: SLICE_W];
        assign rk   = res_o[k*SLICE_W +: SLICE_W];
        assign outr = pipe[RES_STAGE-1];
        assign ek   = nib_ref(outr.op, outr.a, outr.b);

        // Track what this slice received until its result is due
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < RES_STAGE; s++) pipe[s] <= '0;
            end else begin
                pipe[0] <= '{vld: tk.vld, op: tk.op, a: (tk.fwd ? rk : ak), b: bk};
                for (int s = 1; s < RES_STAGE; s++) pipe[s] <= pipe[s-1];
            end
        end

        // R2
        slice_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (outr.vld && is_logic(outr.op)) |-> (rk == ek));

        if (k == 0) begin : g_arith0
            // R3
            low_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (outr.vld && !is_logic(outr.op)) |-> (rk == ek));
        end

        if (k == NUM_SLICES - 1) begin : g_cout
            // R4
            logic_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (outr.vld && is_logic(outr.op)) |-> !cout_o);
        end
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((res_o == '0) && !cout_o));

endmodule

bind blkskew_alu blkskew_alu_chk #(
    .SLICE_W   (SLICE_W),
    .NUM_SLICES(NUM_SLICES)
) u_chk (.*);

// File: tb/test_blkskew_alu.sv
`timescale 1ns/1ps
// Bench for blkskew_alu: drives skewed operands, deskews the result,
// and compares whole words against a 32-bit reference model.
module test_blkskew_alu;

    localparam int SW   = 4;
    localparam int NS   = 8;
    localparam int DW   = SW * NS;
    localparam int LAT  = 8;
    localparam int NOPS = 1200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] a_i, b_i, res_o;
    logic [2:0]    op_i;
    logic          fwd_i, cout_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] ta  [NOPS];
    logic [DW-1:0] tb  [NOPS];
    logic [DW-1:0] er  [NOPS];
    logic [DW-1:0] got [NOPS];
    logic [2:0]    top [NOPS];
    logic          tf  [NOPS];
    logic          tbc [NOPS];
    logic          ec  [NOPS];

    always #10 clk = ~clk;

    blkskew_alu #(.SLICE_W(SW), .NUM_SLICES(NS)) i_blkskew_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .fwd_i (fwd_i),
        .res_o (res_o),
        .cout_o(cout_o)
    );

    function automatic logic [DW:0] ref_alu(input logic [2:0] op,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
        case (op)
            3'd0:       return {1'b0, a} + {1'b0, b};
            3'd1, 3'd7: return {1'b0, a} + {1'b0, ~b} + 33'd1;
            3'd2:       return {1'b0, a & b};
            3'd3:       return {1'b0, a | b};
            3'd4:       return {1'b0, a ^ b};
            3'd5:       return {1'b0, ~(a | b)};
            default:    return {1'b0, ~(a ^ b)};
        endcase
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [DW:0] act, input logic [DW:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_op(input int t, input logic [2:0] op,
                          input logic [DW-1:0] a, input logic [DW-1:0] b);
        top[t] = op; ta[t] = a; tb[t] = b; tf[t] = 1'b0; tbc[t] = 1'b0;
    endtask

    // Random stream, directed corners, a doubling chain, then expectations
    task automatic build();
        logic [DW:0] r;
        logic [DW-1:0] aa;
        for (int t = 0; t < NOPS; t++) begin
            ta[t]  = $urandom;
            tb[t]  = $urandom;
            top[t] = 3'($urandom_range(0, 7));
            tf[t]  = (t >= LAT) && ($urandom_range(0, 3) == 0);
            tbc[t] = tf[t] && ($urandom_range(0, 3) == 0);
        end
        set_op(10, 3'd0, 32'hFFFF_FFFF, 32'h1);        // R3 full ripple
        set_op(11, 3'd1, 32'h0, 32'h1);                // R3 borrow out
        set_op(12, 3'd6, 32'h1234_5678, 32'h1234_5678); // R2 equal
        set_op(13, 3'd5, 32'h0, 32'h0);                // R2 NOR
        set_op(14, 3'd1, 32'h5, 32'h5);                // R4 no borrow
        set_op(15, 3'd0, 32'h0FFF_FFFF, 32'h1);        // R3 seven-slice ripple
        set_op(16, 3'd7, 32'h3, 32'h8000_0000);        // R2 SLT difference
        set_op(17, 3'd6, 32'h1234_5678, 32'h1234_5679); // R2 unequal
        for (int j = 0; j <= 36; j++) begin             // R5 doubling chain
            set_op(100 + LAT * j, 3'd0, 32'h1, 32'h1);
            if (j > 0) begin
                tf[100 + LAT * j]  = 1'b1;
                tbc[100 + LAT * j] = 1'b1;
            end
        end
        for (int t = 0; t < NOPS; t++) begin
            if (tbc[t]) tb[t] = er[t-LAT];
            aa = tf[t] ? er[t-LAT] : ta[t];
            r  = ref_alu(top[t], aa, tb[t]);
            er[t] = r[DW-1:0];
            ec[t] = r[DW];
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        build();
        a_i = '0; b_i = '0; op_i = '0; fwd_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8
        chk((res_o == '0) && !cout_o, "R8 reset state", {cout_o, res_o}, '0);
        for (int n = 0; n < NOPS + 2 * LAT; n++) begin
            if (n > 0) @(negedge clk);
            // Collect skewed result nibbles for their operations
            for (int k = 0; k < NS; k++) begin
                int m;
                m = n - LAT - k;
                if (m >= 0 && m < NOPS) begin
                    got[m][k*SW +: SW] = res_o[k*SW +: SW];
                    if (k == NS - 1) begin
                        string tg;
                        tg = tf[m] ? "R1 R5 R6 R7 forward" :
                             (top[m] inside {3'd0, 3'd1, 3'd7}) ? "R1 R3 R6 R7 arith" :
                             "R1 R2 R6 R7 logic";
                        chk(got[m] == er[m], $sformatf("%s op%0d", tg, m),
                            {1'b0, got[m]}, {1'b0, er[m]});
                        chk(cout_o == ec[m], $sformatf("R4 carry op%0d", m),
                            {32'h0, cout_o}, {32'h0, ec[m]});
                    end
                end
            end
            // Drive nibble k of the operation issued k cycles ago
            for (int k = 0; k < NS; k++) begin
                int m;
                logic [31:0] rnd;
                m = n - k;
                rnd = $urandom;
                if (m >= 0 && m < NOPS) begin
                    a_i[k*SW +: SW] = ta[m][k*SW +: SW];
                    b_i[k*SW +: SW] = tb[m][k*SW +: SW];
                end else begin
                    a_i[k*SW +: SW] = rnd[SW-1:0];
                    b_i[k*SW +: SW] = rnd[2*SW-1:SW];
                end
            end
            op_i  = (n < NOPS) ? top[n] : 3'd0;
            fwd_i = (n < NOPS) ? tf[n] : 1'b0;
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule